// File: doc/BRIEF.md
# Position Compare Gate and Pulse Sequencer

This block runs a capture sequence for a scanning experiment. An arm event enables it. While armed it opens a series of gate windows, and inside each open gate it opens a series of pulse windows. Each gate and each pulse can be placed in one of three ways: by where a selected encoder count stands (position compare, either direction), by clock ticks elapsed since the enclosing layer became active, or by an external trigger line. The two layers pick their sources independently, so sources can be mixed. For example, a gate can open over a position range while the pulses inside it repeat at a fixed tick interval.

Every pulse event latches a record: the free-running timestamp and all four encoder counts, each taken in the cycle in which the pulse event was detected. The record is pushed out on a valid/ready stream and is never requested. The output has one holding stage. While a record is valid and not yet accepted, it and `rec_valid` stay stable. A record is taken when `rec_valid` and `rec_ready` are both high at a clock edge. A pulse event that arrives while a record is still waiting is dropped, and the sticky `overflow` pin goes high. The block disarms itself when its last configured gate closes. A disarm request cuts off gates and pulses at once.

Top module: `pcap_sequencer`

## Requirements
- R1: After reset `armed`, `gate_out`, `pulse_out`, `rec_valid` and `overflow` are all low and the timestamp restarts from 0.
- R2: With `arm_src`=0 a high `arm_req` sampled at an edge sets `armed` from the next cycle. With `arm_src`=1 a rising edge of `arm_ext` does the same.
- R3: Source code 1 selects time mode, which counts ticks from the first cycle the layer is enabled (tick 0). Window n opens the cycle after tick start+n*step and stays open for width cycles. In time/time operation the pulse event with arm at timestamp Ta lands at timestamp Ta+gs+k*gst+1+ps+j*pst, for gate k and pulse j, when ps+j*pst < gate width and j < pulse count.
- R4: Source code 0 selects position mode on encoder `cmp_sel`. With dir=0 a window opens once the count is >= its threshold and closes at threshold+width. With dir=1 it opens once the count is <= threshold and closes at threshold-width. Each window is applied one cycle after the compare. The threshold for window n is start±n*step. Code 3 behaves as code 0.
- R5: Source code 2 selects the external line. The window opens the cycle after a rising edge of that line and closes the cycle after a falling edge. A pulse event is a detected rising edge.
- R6: A layer stops after `count` windows, and a count of 0 means no limit. When the gate layer finishes, `armed` drops on the following cycle.
- R7: A high `disarm_req` at an edge makes `armed`, `gate_out` and `pulse_out` low in the next cycle. No further records follow.
- R8: Each record holds the timestamp and the four encoder counts from the cycle of its pulse event. Encoder g sits at `rec_pos[32g+31:32g]`. `rec_valid` rises in the next cycle.
- R9: While `rec_valid` is high and `rec_ready` is low, the record does not change. A new pulse event in that state is dropped and sets `overflow`. `overflow` clears when the block is armed again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| arm_src | input | 1 | Arm source: 0 request pin, 1 external edge |
| arm_req | input | 1 | Arm request |
| arm_ext | input | 1 | External arm line (synchronous) |
| disarm_req | input | 1 | Disarm request, wins over arming |
| cmp_sel | input | 2 | Encoder used for position compare |
| gate_src | input | 2 | Gate source: 0 position, 1 time, 2 external |
| gate_dir | input | 1 | Gate compare direction: 0 rising counts, 1 falling |
| gate_start | input | 32 | First gate threshold (counts or ticks) |
| gate_width | input | 32 | Gate length |
| gate_step | input | 32 | Gate repeat spacing |
| gate_count | input | 16 | Number of gates, 0 unlimited |
| gate_ext | input | 1 | External gate line |
| pulse_src | input | 2 | Pulse source, same coding as gates |
| pulse_dir | input | 1 | Pulse compare direction |
| pulse_start | input | 32 | First pulse threshold |
| pulse_width | input | 32 | Pulse length |
| pulse_step | input | 32 | Pulse repeat spacing |
| pulse_count | input | 16 | Pulses per gate, 0 unlimited |
| pulse_ext | input | 1 | External pulse line |
| enc_pos | input | 128 | Four signed encoder counts |
| armed | output | 1 | Sequence armed |
| gate_out | output | 1 | Gate window |
| pulse_out | output | 1 | Pulse window |
| rec_valid | output | 1 | Record available |
| rec_ready | input | 1 | Consumer accepts record |
| rec_time | output | 32 | Captured timestamp |
| rec_pos | output | 128 | Captured encoder counts |
| overflow | output | 1 | Record lost while output stalled |

## Verification
The bench sweeps small time/time configurations and checks every record's timestamp against the closed-form formula. A one-cycle slip in any layer's latency shifts every expected value, and a pulse that leaks past the gate's closing cycle adds a record. Position ramps run in both directions and check that each window opens exactly at its threshold. A design that compared with the wrong sense, or stepped from the close point instead of the open point, would capture the wrong counts. Separate runs cover the external edge paths, disarming in the middle of a gate, unlimited pulse counts, and a stalled consumer. A design that overwrote the pending record or never raised `overflow` would show a changed timestamp or a low flag.

// File: rtl/pcap_pkg.sv
`timescale 1ns/1ps
package pcap_pkg;
  typedef enum logic [1:0] {
    SRC_POS  = 2'd0,
    SRC_TIME = 2'd1,
    SRC_EXT  = 2'd2,
    SRC_RSVD = 2'd3
  } src_e;

  typedef enum logic [1:0] {
    ST_WAIT = 2'd0,
    ST_OPEN = 2'd1,
    ST_DONE = 2'd2
  } lstate_e;
endpackage

// File: rtl/pcap_layer.sv
`timescale 1ns/1ps
module pcap_layer
  import pcap_pkg::*;
#(
  parameter int W  = 32,
  parameter int CW = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                en,
  input  src_e                src,
  input  logic                dir_neg,
  input  logic signed [W-1:0] start,
  input  logic signed [W-1:0] width,
  input  logic signed [W-1:0] step,
  input  logic [CW-1:0]       count,
  input  logic signed [W-1:0] pos,
  input  logic                ext,
  output logic                win,
  output logic                fire,
  output logic                done
);
  lstate_e             st;
  logic signed [W-1:0] thr;
  logic signed [W-1:0] base;
  logic [W-1:0]        elapsed;
  logic [CW-1:0]       idx;
  logic                ext_q;

  logic                use_time;
  logic                descend;
  logic signed [W-1:0] metric;
  logic                reached;
  logic                open_hit;
  logic                close_hit;
  logic [CW-1:0]       idx_nx;
  logic                last_win;

  function automatic logic signed [W-1:0] advance(
    input logic signed [W-1:0] a,
    input logic signed [W-1:0] d,
    input logic                neg
  );
    return neg ? (a - d) : (a + d);
  endfunction

  assign use_time  = (src == SRC_TIME);
  assign descend   = dir_neg && !use_time;
  assign metric    = use_time ? $signed(elapsed) : pos;
  assign reached   = descend ? (metric <= thr) : (metric >= thr);
  assign open_hit  = (src == SRC_EXT) ? (ext && !ext_q) : reached;
  assign close_hit = (src == SRC_EXT) ? (!ext && ext_q) : reached;
  assign idx_nx    = idx + 1'b1;
  assign last_win  = (count != '0) && (idx_nx == count);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ext_q <= 1'b0;
    end else begin
      ext_q <= ext;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !en) begin
      st      <= ST_WAIT;
      thr     <= start;
      base    <= start;
      idx     <= '0;
      elapsed <= '0;
    end else begin
      elapsed <= elapsed + 1'b1;
      unique case (st)
        ST_WAIT: begin
          if (open_hit) begin
            st   <= ST_OPEN;
            base <= thr;
            thr  <= advance(thr, width, descend);
          end
        end
        ST_OPEN: begin
          if (close_hit) begin
            idx <= idx_nx;
            thr <= advance(base, step, descend);
            st  <= last_win ? ST_DONE : ST_WAIT;
          end
        end
        default: st <= ST_DONE;
      endcase
    end
  end

  assign win  = en && (st == ST_OPEN);
  assign fire = en && (st == ST_WAIT) && open_hit;
  assign done = (st == ST_DONE);

  // R5
  open_follows_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> (win || !en));
endmodule

// File: rtl/pcap_capture.sv
`timescale 1ns/1ps
module pcap_capture #(
  parameter int POS_W  = 32,
  parameter int TIME_W = 32,
  parameter int N_ENC  = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   fire,
  input  logic                   clr,
  input  logic [TIME_W-1:0]      ts,
  input  logic [POS_W*N_ENC-1:0] enc_pos,
  input  logic                   rec_ready,
  output logic                   rec_valid,
  output logic [TIME_W-1:0]      rec_time,
  output logic [POS_W*N_ENC-1:0] rec_pos,
  output logic                   overflow
);
  logic take;
  logic [POS_W-1:0] pos_q [N_ENC];

  assign take = fire && (!rec_valid || rec_ready);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rec_valid <= 1'b0;
      rec_time  <= '0;
    end else if (take) begin
      rec_valid <= 1'b1;
      rec_time  <= ts;
    end else if (rec_ready) begin
      rec_valid <= 1'b0;
    end
  end

  for (genvar g = 0; g < N_ENC; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        pos_q[g] <= '0;
      end else if (take) begin
        pos_q[g] <= enc_pos[g*POS_W +: POS_W];
      end
    end
    assign rec_pos[g*POS_W +: POS_W] = pos_q[g];
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      overflow <= 1'b0;
    end else if (fire && rec_valid && !rec_ready) begin
      overflow <= 1'b1;
    end
  end

  // R9
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rec_valid && !rec_ready) |=> (rec_valid && $stable(rec_time) && $stable(rec_pos)));

  // R9
  overflow_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(overflow) |-> rec_valid);
endmodule

// File: rtl/pcap_sequencer.sv
`timescale 1ns/1ps
module pcap_sequencer
  import pcap_pkg::*;
#(
  parameter int POS_W  = 32,
  parameter int TIME_W = 32,
  parameter int N_ENC  = 4,
  parameter int CNT_W  = 16,
  localparam int SEL_W = (N_ENC > 1) ? $clog2(N_ENC) : 1,
  localparam int BUS_W = POS_W * N_ENC
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              arm_src,
  input  logic              arm_req,
  input  logic              arm_ext,
  input  logic              disarm_req,
  input  logic [SEL_W-1:0]  cmp_sel,
  input  logic [1:0]        gate_src,
  input  logic              gate_dir,
  input  logic [POS_W-1:0]  gate_start,
  input  logic [POS_W-1:0]  gate_width,
  input  logic [POS_W-1:0]  gate_step,
  input  logic [CNT_W-1:0]  gate_count,
  input  logic              gate_ext,
  input  logic [1:0]        pulse_src,
  input  logic              pulse_dir,
  input  logic [POS_W-1:0]  pulse_start,
  input  logic [POS_W-1:0]  pulse_width,
  input  logic [POS_W-1:0]  pulse_step,
  input  logic [CNT_W-1:0]  pulse_count,
  input  logic              pulse_ext,
  input  logic [BUS_W-1:0]  enc_pos,
  output logic              armed,
  output logic              gate_out,
  output logic              pulse_out,
  output logic              rec_valid,
  input  logic              rec_ready,
  output logic [TIME_W-1:0] rec_time,
  output logic [BUS_W-1:0]  rec_pos,
  output logic              overflow
);
  logic [TIME_W-1:0]       ts_q;
  logic                    arm_ext_q;
  logic                    arm_evt;
  logic                    arm_start;
  logic                    gate_fire;
  logic                    gate_done;
  logic                    pulse_fire;
  logic                    pulse_done;
  logic signed [POS_W-1:0] enc_arr [N_ENC];
  logic signed [POS_W-1:0] pos_cmp;

  for (genvar g = 0; g < N_ENC; g++) begin : g_enc
    assign enc_arr[g] = $signed(enc_pos[g*POS_W +: POS_W]);
  end
  assign pos_cmp = enc_arr[cmp_sel];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ts_q      <= '0;
      arm_ext_q <= 1'b0;
    end else begin
      ts_q      <= ts_q + 1'b1;
      arm_ext_q <= arm_ext;
    end
  end

  assign arm_evt   = arm_src ? (arm_ext && !arm_ext_q) : arm_req;
  assign arm_start = !armed && arm_evt && !disarm_req;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed <= 1'b0;
    end else if (disarm_req || (armed && gate_done)) begin
      armed <= 1'b0;
    end else if (arm_start) begin
      armed <= 1'b1;
    end
  end

  pcap_layer #(.W(POS_W), .CW(CNT_W)) i_gate (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (armed),
    .src     (src_e'(gate_src)),
    .dir_neg (gate_dir),
    .start   ($signed(gate_start)),
    .width   ($signed(gate_width)),
    .step    ($signed(gate_step)),
    .count   (gate_count),
    .pos     (pos_cmp),
    .ext     (gate_ext),
    .win     (gate_out),
    .fire    (gate_fire),
    .done    (gate_done)
  );

  pcap_layer #(.W(POS_W), .CW(CNT_W)) i_pulse (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (gate_out),
    .src     (src_e'(pulse_src)),
    .dir_neg (pulse_dir),
    .start   ($signed(pulse_start)),
    .width   ($signed(pulse_width)),
    .step    ($signed(pulse_step)),
    .count   (pulse_count),
    .pos     (pos_cmp),
    .ext     (pulse_ext),
    .win     (pulse_out),
    .fire    (pulse_fire),
    .done    (pulse_done)
  );

  pcap_capture #(.POS_W(POS_W), .TIME_W(TIME_W), .N_ENC(N_ENC)) i_cap (
    .clk       (clk),
    .rst_n     (rst_n),
    .fire      (pulse_fire),
    .clr       (arm_start),
    .ts        (ts_q),
    .enc_pos   (enc_pos),
    .rec_ready (rec_ready),
    .rec_valid (rec_valid),
    .rec_time  (rec_time),
    .rec_pos   (rec_pos),
    .overflow  (overflow)
  );

  // R7
  disarm_cut_chk: assert property (@(posedge clk) disable iff (!rst_n)
    disarm_req |=> (!armed && !gate_out && !pulse_out));

  // R6
  auto_disarm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && gate_done) |=> !armed);

  // R8
  capture_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_fire |=> rec_valid);

  // R3
  pulse_in_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_out |-> (gate_out && armed));

  // R6
  gate_idle_when_disarmed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !armed |-> !(gate_fire || pulse_fire || (pulse_done && pulse_out)));
endmodule

// File: tb/test_pcap_sequencer.sv
`timescale 1ns/1ps
module test_pcap_sequencer;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic arm_src = 1'b0, arm_req = 1'b0, arm_ext = 1'b0, disarm_req = 1'b0;
  logic [1:0] cmp_sel = 2'd0;
  logic [1:0] gate_src = 2'd1, pulse_src = 2'd1;
  logic gate_dir = 1'b0, pulse_dir = 1'b0, gate_ext = 1'b0, pulse_ext = 1'b0;
  logic [31:0] gate_start = 0, gate_width = 1, gate_step = 2;
  logic [31:0] pulse_start = 0, pulse_width = 1, pulse_step = 2;
  logic [15:0] gate_count = 1, pulse_count = 1;
  logic [127:0] enc_pos = '0;
  logic armed, gate_out, pulse_out, rec_valid, overflow;
  logic rec_ready = 1'b1;
  logic [31:0] rec_time;
  logic [127:0] rec_pos;

  int tests = 0, fails = 0;
  int tsm = 0;
  bit pos_auto = 1'b1, mon_en = 1'b0;
  int ramp_val = 0, ramp_step = 0;
  int nrec = 0;
  int rt [0:63];
  int rp [0:63][0:3];

  always #5 clk = ~clk;

  always @(posedge clk) tsm <= rst_n ? tsm + 1 : 0;

  pcap_sequencer i_pcap_sequencer (
    .clk(clk), .rst_n(rst_n), .arm_src(arm_src), .arm_req(arm_req), .arm_ext(arm_ext),
    .disarm_req(disarm_req), .cmp_sel(cmp_sel),
    .gate_src(gate_src), .gate_dir(gate_dir), .gate_start(gate_start), .gate_width(gate_width),
    .gate_step(gate_step), .gate_count(gate_count), .gate_ext(gate_ext),
    .pulse_src(pulse_src), .pulse_dir(pulse_dir), .pulse_start(pulse_start),
    .pulse_width(pulse_width), .pulse_step(pulse_step), .pulse_count(pulse_count),
    .pulse_ext(pulse_ext), .enc_pos(enc_pos), .armed(armed), .gate_out(gate_out),
    .pulse_out(pulse_out), .rec_valid(rec_valid), .rec_ready(rec_ready), .rec_time(rec_time),
    .rec_pos(rec_pos), .overflow(overflow)
  );

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    if (mon_en && rec_valid && rec_ready && nrec < 64) begin
      rt[nrec] = int'(rec_time);
      for (int i = 0; i < 4; i++) rp[nrec][i] = int'($signed(rec_pos[i*32 +: 32]));
      nrec++;
    end
    if (pos_auto) begin
      for (int i = 0; i < 4; i++) enc_pos[i*32 +: 32] = 32'(tsm * (i + 1) + i * 1000);
    end else begin
      ramp_val = ramp_val + ramp_step;
      enc_pos = '0;
      enc_pos[31:0] = 32'(ramp_val);
    end
  endtask

  task automatic arm_now(output int ta);
    arm_src = 1'b0;
    ta = tsm + 1;
    arm_req = 1'b1;
    tick();
    arm_req = 1'b0;
  endtask

  task automatic wait_disarm();
    for (int n = 0; n < 600 && armed; n++) tick();
  endtask

  task automatic run_time(input int gs, gw, gst, gc, ps, pst, pc);
    int ta, e, exp_t;
    gate_src = 2'd1; pulse_src = 2'd1; pos_auto = 1'b1; rec_ready = 1'b1;
    gate_start = gs; gate_width = gw; gate_step = gst; gate_count = 16'(gc);
    pulse_start = ps; pulse_width = 1; pulse_step = pst; pulse_count = 16'(pc);
    nrec = 0; mon_en = 1'b1;
    tick();
    arm_now(ta);
    wait_disarm();
    repeat (3) tick();
    chk(!armed, "R6 auto disarm after last gate", armed, 0);
    e = 0;
    for (int k = 0; k < gc; k++) begin
      for (int j = 0; j < pc; j++) begin
        if (ps + j * pst < gw) begin
          exp_t = ta + gs + k * gst + 1 + ps + j * pst;
          chk(e < nrec && rt[e] == exp_t, "R3 pulse timestamp", rt[e], exp_t);
          for (int i = 0; i < 4; i++)
            chk(e < nrec && rp[e][i] == exp_t * (i + 1) + i * 1000, "R8 captured position",
                rp[e][i], exp_t * (i + 1) + i * 1000);
          e++;
        end
      end
    end
    chk(nrec == e, "R6 record count", nrec, e);
    mon_en = 1'b0;
  endtask

  initial begin
    #1_000_000;
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", tsm, 0);
    $display("  [TB] %0d tests run, %0d failed", tests + 1, fails);
    $finish;
  end

  initial begin
    int ta, n0;
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    // R1 reset state
    chk(!armed && !gate_out && !pulse_out, "R1 outputs idle", {armed, gate_out, pulse_out}, 0);
    chk(!rec_valid && !overflow, "R1 stream idle", {rec_valid, overflow}, 0);

    // R3 / R6 / R8 time/time sweep
    for (int gs = 0; gs <= 3; gs += 3)
      for (int gw = 6; gw <= 9; gw += 3)
        for (int gst = 12; gst <= 15; gst += 3)
          for (int gc = 1; gc <= 3; gc++)
            for (int ps = 0; ps <= 1; ps++)
              for (int pst = 2; pst <= 3; pst++)
                for (int pc = 1; pc <= 5; pc += 2)
                  run_time(gs, gw, gst, gc, ps, pst, pc);

    // R4 position gates rising, time pulses, unlimited pulse count (R6)
    pos_auto = 1'b0; ramp_val = 50; ramp_step = 0; cmp_sel = 2'd0;
    gate_src = 2'd0; gate_dir = 1'b0; gate_start = 100; gate_width = 40; gate_step = 100; gate_count = 2;
    pulse_src = 2'd1; pulse_start = 0; pulse_width = 3; pulse_step = 10; pulse_count = 0;
    nrec = 0; mon_en = 1'b1;
    tick(); tick();
    arm_now(ta);
    chk(armed, "R2 arm request", armed, 1);
    ramp_step = 1;
    wait_disarm();
    chk(nrec == 8, "R4 rising record count", nrec, 8);
    for (int g = 0; g < 2; g++)
      for (int j = 0; j < 4; j++)
        chk(rp[g*4+j][0] == 101 + g * 100 + j * 10, "R4 rising capture count",
            rp[g*4+j][0], 101 + g * 100 + j * 10);
    chk(!armed, "R6 auto disarm position", armed, 0);

    // R4 position gate falling
    ramp_val = 0; ramp_step = 0;
    gate_dir = 1'b1; gate_start = -10; gate_width = 20; gate_step = 50; gate_count = 1;
    pulse_start = 2; pulse_width = 2; pulse_step = 5; pulse_count = 2;
    nrec = 0;
    tick();
    arm_now(ta);
    ramp_step = -1;
    wait_disarm();
    chk(nrec == 2, "R4 falling record count", nrec, 2);
    chk(rp[0][0] == -13, "R4 falling first", rp[0][0], -13);
    chk(rp[1][0] == -18, "R4 falling second", rp[1][0], -18);

    // R5 external arm, external gate, position pulses
    ramp_val = 0; ramp_step = 0; gate_dir = 1'b0;
    arm_src = 1'b1; gate_src = 2'd2; gate_count = 1;
    pulse_src = 2'd0; pulse_dir = 1'b0; pulse_start = 5; pulse_width = 1; pulse_step = 3; pulse_count = 3;
    nrec = 0;
    tick();
    arm_ext = 1'b1;
    tick();
    chk(armed, "R2 external arm edge", armed, 1);
    arm_ext = 1'b0;
    chk(!gate_out, "R5 gate closed before edge", gate_out, 0);
    gate_ext = 1'b1;
    tick();
    chk(gate_out, "R5 gate opens after rising edge", gate_out, 1);
    ramp_step = 1;
    repeat (20) tick();
    gate_ext = 1'b0;
    tick();
    chk(!gate_out, "R5 gate closes after falling edge", gate_out, 0);
    tick();
    chk(!armed, "R6 auto disarm external", armed, 0);
    chk(nrec == 3, "R5 pulse records", nrec, 3);
    for (int j = 0; j < 3; j++)
      chk(rp[j][0] == 5 + 3 * j, "R4 pulse threshold", rp[j][0], 5 + 3 * j);
    arm_src = 1'b0;

    // R7 disarm mid gate
    pos_auto = 1'b1; gate_src = 2'd1; pulse_src = 2'd1;
    gate_start = 0; gate_width = 100; gate_step = 200; gate_count = 1;
    pulse_start = 0; pulse_width = 2; pulse_step = 4; pulse_count = 0;
    nrec = 0;
    tick();
    arm_now(ta);
    repeat (10) tick();
    disarm_req = 1'b1;
    tick();
    disarm_req = 1'b0;
    chk(!armed && !gate_out && !pulse_out, "R7 disarm cuts outputs", {armed, gate_out, pulse_out}, 0);
    n0 = nrec;
    chk(n0 > 0, "R7 records before disarm", n0, 1);
    repeat (20) tick();
    chk(nrec == n0, "R7 no records after disarm", nrec, n0);
    mon_en = 1'b0;

    // R9 stalled consumer
    rec_ready = 1'b0;
    gate_width = 50; gate_count = 1;
    pulse_start = 0; pulse_width = 1; pulse_step = 5; pulse_count = 3;
    tick();
    arm_now(ta);
    repeat (30) tick();
    chk(rec_valid, "R9 record held", rec_valid, 1);
    chk(rec_time == 32'(ta + 1), "R9 oldest record kept", rec_time, ta + 1);
    chk(overflow, "R9 overflow raised", overflow, 1);
    rec_ready = 1'b1;
    tick();
    chk(!rec_valid, "R9 record accepted", rec_valid, 0);
    wait_disarm();
    arm_now(ta);
    chk(!overflow, "R9 overflow cleared on arm", overflow, 0);
    disarm_req = 1'b1;
    tick();
    disarm_req = 1'b0;
    tick();

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule